// File: doc/BRIEF.md
# Repeating Alarm Match Unit

This block holds the four alarm setpoints of a real-time clock (seconds, minutes, hours and day of month), each stored in BCD in one byte. A separate time-of-day counter supplies the current time in BCD together with a one-second strobe. On each rising edge of that strobe the unit compares the current time with the setpoints and, on a match, issues a one-cycle interrupt pulse.

Bit 7 of each alarm byte is a repeat mask. The masks only count in a nested order: date first, then hours, then minutes, then seconds. Together they pick one of five repetition rates: monthly, daily, hourly, once a minute or every second. The setpoints are loaded through a byte-wide register port. Any write whose BCD value is out of range for its field is dropped. Every stored byte can be read back on a combinational read port.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset all four alarm bytes read 0x00 and `alarm_irq` is low.
- R2: A write to the seconds (select 0) or minutes (select 1) byte is stored only when bits 6:0 form valid BCD in 0..59. A rejected write leaves the byte unchanged.
- R3: A write to the hours byte (select 2) is stored only when bits 5:0 form valid BCD in 0..23. Otherwise the byte is unchanged.
- R4: A write to the date byte (select 3) is stored only when bits 5:0 have a low digit of 9 or less and are nonzero. Otherwise the byte is unchanged.
- R5: `rd_data` shows the whole byte at `rd_sel` (0 seconds, 1 minutes, 2 hours, 3 date) exactly as accepted, including bit 7 and any unused upper bits.
- R6: With all four bit-7 masks clear, the alarm fires only when seconds, minutes, hours and date all match. Seconds and minutes compare bits 6:0; hours and date compare bits 5:0.
- R7: With only the date mask set, the date is ignored and seconds, minutes and hours must match (daily).
- R8: With the date and hour masks set and the minute and second masks clear, only seconds and minutes must match (hourly).
- R9: With the date, hour and minute masks set and the second mask clear, only seconds must match (every minute).
- R10: With any other mask combination, every tick fires the alarm.
- R11: `alarm_irq` is high for exactly one clock, in the cycle after a rising edge of `sec_tick`. A tick held high fires at most once.
- R12: While `irq_en` is low on the tick edge, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Alarm byte written: 0 sec, 1 min, 2 hour, 3 date |
| wr_data | input | 8 | Write byte, bit 7 is the repeat mask |
| rd_sel | input | 2 | Alarm byte shown on rd_data |
| rd_data | output | 8 | Stored alarm byte |
| sec_tick | input | 1 | One-second strobe from the time counter |
| irq_en | input | 1 | Alarm interrupt enable |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
If a range check is wrong, a stored byte differs from the bench model. This shows on `rd_data` in the cycle right after the write. If a mask decode or compare slice is wrong, the pulse is missing or extra one clock after the tick edge. The sweep of all sixteen mask combinations, with each field mismatched in turn, exposes every care-bit error at that single sample point. A pulse that is too wide, or a second pulse from a held tick, shows as `alarm_irq` still high one cycle later.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_FLD  = 4;
    localparam int SEL_W    = $clog2(NUM_FLD);
    localparam int SEC_W    = 7;
    localparam int MIN_W    = 7;
    localparam int HOUR_W   = 6;
    localparam int DATE_W   = 6;
    localparam int MASK_BIT = DATA_W - 1;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DATE = 2'd3
    } fld_e;

    // width of the BCD value that is range-checked and compared per field
    function automatic int fld_w(input int idx);
        case (idx)
            0:       return SEC_W;
            1:       return MIN_W;
            2:       return HOUR_W;
            default: return DATE_W;
        endcase
    endfunction

    typedef struct packed {
        logic [NUM_FLD-1:0][DATA_W-1:0] regs;
        logic                           tick_q;
        logic                           irq;
    } alm_state_t;
endpackage

// File: rtl/alarm_bcd_check.sv
module alarm_bcd_check #(
    parameter int KIND = 0,
    parameter int W    = 7
) (
    input  logic [W-1:0] val,
    output logic         ok
);
    localparam int TENS_W = W - 4;

    logic [3:0]        units;
    logic [TENS_W-1:0] tens;

    assign units = val[3:0];
    assign tens  = val[W-1:4];

    generate
        if (KIND <= 1) begin : g_sixty
            always_comb ok = (units <= 4'd9) && (tens <= TENS_W'(5));
        end else if (KIND == 2) begin : g_day_hours
            always_comb ok = (units <= 4'd9) &&
                             ((tens < TENS_W'(2)) ||
                              ((tens == TENS_W'(2)) && (units <= 4'd3)));
        end else begin : g_month_day
            always_comb ok = (units <= 4'd9) && (val != '0);
        end
    endgenerate
endmodule

// File: rtl/alarm_rpt_decode.sv
module alarm_rpt_decode #(
    parameter int NF = 4
) (
    input  logic [NF-1:0] mask,
    output logic [NF-1:0] care
);
    // masks count only in nested order from the top field downward
    always_comb begin
        care = '0;
        for (int k = 0; k <= NF; k++) begin
            logic [NF-1:0] pat;
            pat = '0;
            for (int j = 0; j < NF; j++) begin
                if (j >= NF - k) pat[j] = 1'b1;
            end
            if (k < NF && mask == pat) begin
                care = '0;
                for (int j = 0; j < NF; j++) begin
                    if (j < NF - k) care[j] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int W = 7
) (
    input  logic [W-1:0] set_val,
    input  logic [W-1:0] now_val,
    input  logic         care,
    output logic         hit
);
    always_comb hit = !care || (set_val == now_val);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sec_tick,
    input  logic              irq_en,
    input  logic [SEC_W-1:0]  now_sec,
    input  logic [MIN_W-1:0]  now_min,
    input  logic [HOUR_W-1:0] now_hour,
    input  logic [DATE_W-1:0] now_date,
    output logic              alarm_irq
);
    alm_state_t state_d, state_q;

    logic [NUM_FLD-1:0][DATA_W-1:0] alm_regs;
    logic [NUM_FLD-1:0]             wr_ok;
    logic [NUM_FLD-1:0]             fld_hit;
    logic [NUM_FLD-1:0]             rpt_mask;
    logic [NUM_FLD-1:0]             fld_care;

    assign alm_regs = state_q.regs;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FLD; gi++) begin : g_fld
            localparam int W = fld_w(gi);
            logic [W-1:0] now_f;

            if (gi == 0) begin : g_s
                assign now_f = now_sec;
            end else if (gi == 1) begin : g_m
                assign now_f = now_min;
            end else if (gi == 2) begin : g_h
                assign now_f = now_hour;
            end else begin : g_d
                assign now_f = now_date;
            end

            alarm_bcd_check #(.KIND(gi), .W(W)) u_chk (
                .val (wr_data[W-1:0]),
                .ok  (wr_ok[gi])
            );

            alarm_field_cmp #(.W(W)) u_cmp (
                .set_val (alm_regs[gi][W-1:0]),
                .now_val (now_f),
                .care    (fld_care[gi]),
                .hit     (fld_hit[gi])
            );

            assign rpt_mask[gi] = alm_regs[gi][MASK_BIT];
        end
    endgenerate

    alarm_rpt_decode #(.NF(NUM_FLD)) u_rpt (
        .mask (rpt_mask),
        .care (fld_care)
    );

    always_comb begin
        state_d        = state_q;
        state_d.tick_q = sec_tick;
        if (wr_en && wr_ok[wr_sel]) begin
            state_d.regs[wr_sel] = wr_data;
        end
        state_d.irq = sec_tick && !state_q.tick_q && irq_en && (&fld_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data   = alm_regs[rd_sel];
    assign alarm_irq = state_q.irq;
endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [1:0]      wr_sel,
    input logic [7:0]      wr_data,
    input logic            sec_tick,
    input logic            irq_en,
    input logic            alarm_irq,
    input logic [3:0][7:0] regs
);
    function automatic logic bcd_le(input logic [7:0] v, input int lim);
        int u, t;
        u = int'(v[3:0]);
        t = int'(v[7:4]);
        return (u <= 9) && (t * 10 + u <= lim);
    endfunction

    logic ok_60, ok_24, ok_dt, tick_prev, every_sec;
    logic [3:0] masks;

    assign ok_60 = bcd_le({1'b0, wr_data[6:0]}, 59);
    assign ok_24 = bcd_le({2'b0, wr_data[5:0]}, 23);
    assign ok_dt = (wr_data[3:0] <= 4'd9) && (wr_data[5:0] != 6'd0);
    assign masks = {regs[3][7], regs[2][7], regs[1][7], regs[0][7]};
    assign every_sec = !(masks == 4'b0000 || masks == 4'b1000 ||
                         masks == 4'b1100 || masks == 4'b1110);

    always_ff @(posedge clk) begin
        if (!rst_n) tick_prev <= 1'b0;
        else        tick_prev <= sec_tick;
    end

    AST_SEC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && !ok_60) |=> $stable(regs[0])); // R2
    AST_MIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && ok_60) |=> (regs[1] == $past(wr_data))); // R2
    AST_HOUR_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && !ok_24) |=> $stable(regs[2])); // R3
    AST_DATE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && !ok_dt) |=> $stable(regs[3])); // R4
    AST_EVERY_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !tick_prev && irq_en && every_sec) |=> alarm_irq); // R10
    AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |=> !alarm_irq); // R11
    AST_TICK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> ($past(sec_tick) && !$past(tick_prev))); // R11
    AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> $past(irq_en)); // R12
endmodule

bind alarm_match_unit alarm_match_unit_chk u_alarm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .sec_tick  (sec_tick),
    .irq_en    (irq_en),
    .alarm_irq (alarm_irq),
    .regs      (alm_regs)
);

// File: tb/alarm_match_unit_bench.sv
`timescale 1ns/1ps
module alarm_match_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       sec_tick = 1'b0;
    logic       irq_en = 1'b1;
    logic [6:0] now_sec = '0;
    logic [6:0] now_min = '0;
    logic [5:0] now_hour = '0;
    logic [5:0] now_date = '0;
    logic       alarm_irq;

    int vectors = 0;
    int fails = 0;
    int model [4];

    always #2 clk = ~clk;

    alarm_match_unit u_alarm_match_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .sec_tick(sec_tick), .irq_en(irq_en), .now_sec(now_sec),
        .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
        .alarm_irq(alarm_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit accept(input int sel, input int v);
        int lo, u, t;
        lo = (sel < 2) ? (v % 128) : (v % 64);
        u = lo % 16;
        t = lo / 16;
        if (sel < 2)  return (u <= 9) && (t * 10 + u <= 59);
        if (sel == 2) return (u <= 9) && (t * 10 + u <= 23);
        return (u <= 9) && (lo != 0);
    endfunction

    task automatic wr(input int sel, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(v);
        @(negedge clk);
        wr_en = 1'b0;
        if (accept(sel, v)) model[sel] = v;
    endtask

    task automatic rd_chk(input int sel, input string tag);
        rd_sel = 2'(sel);
        #1;
        chk(tag, int'(rd_data), model[sel]);
    endtask

    // one tick edge; returns irq one cycle later, checks it drops next cycle
    task automatic tick_once(output int got);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        got = int'(alarm_irq);
        sec_tick = 1'b0;
        @(negedge clk);
        chk("R11 pulse ends", int'(alarm_irq), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int got;
        for (int i = 0; i < 4; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 4; i++) rd_chk(i, "R1 reset byte");
        chk("R1 irq after reset", int'(alarm_irq), 0);

        // R2 R3 R4 exhaustive write sweep with readback
        for (int sel = 0; sel < 4; sel++) begin
            for (int v = 0; v < 256; v++) begin
                wr(sel, v);
                rd_chk(sel, (sel < 2) ? "R2 sec/min write" :
                            (sel == 2) ? "R3 hour write" : "R4 date write");
            end
        end

        // R5 upper bits preserved
        wr(2, 8'hC5); rd_chk(2, "R5 hour upper bits");
        chk("R5 hour literal", int'(rd_data), 8'hC5);
        wr(3, 8'hE9); rd_chk(3, "R5 date upper bits");
        chk("R5 date literal", int'(rd_data), 8'hE9);

        // R6..R10 mask sweep: every mask combination, each field mismatched
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 5; p++) begin
                int care, exp_fire;
                string tag;
                wr(0, ((m & 1) ? 8'h80 : 0) | 8'h25);
                wr(1, ((m & 2) ? 8'h80 : 0) | 8'h41);
                wr(2, ((m & 4) ? 8'h80 : 0) | 8'h13);
                wr(3, ((m & 8) ? 8'h80 : 0) | 8'h15);
                now_sec  = (p == 1) ? 7'h26 : 7'h25;
                now_min  = (p == 2) ? 7'h42 : 7'h41;
                now_hour = (p == 3) ? 6'h14 : 6'h13;
                now_date = (p == 4) ? 6'h16 : 6'h15;
                if (m == 0)       begin care = 15; tag = "R6 monthly"; end
                else if (m == 8)  begin care = 7;  tag = "R7 daily"; end
                else if (m == 12) begin care = 3;  tag = "R8 hourly"; end
                else if (m == 14) begin care = 1;  tag = "R9 per-minute"; end
                else              begin care = 0;  tag = "R10 every second"; end
                exp_fire = (p == 0) ? 1 : (((care >> (p - 1)) & 1) ? 0 : 1);
                tick_once(got);
                chk(tag, got, exp_fire);
            end
        end

        // R12 enable low suppresses (masks all set, every second mode)
        wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h81);
        irq_en = 1'b0;
        tick_once(got);
        chk("R12 enable low", got, 0);
        irq_en = 1'b1;

        // R11 held tick fires exactly once
        @(negedge clk);
        chk("R11 idle before tick", int'(alarm_irq), 0);
        sec_tick = 1'b1;
        @(negedge clk);
        chk("R11 first cycle", int'(alarm_irq), 1);
        @(negedge clk);
        chk("R11 held tick second cycle", int'(alarm_irq), 0);
        @(negedge clk);
        chk("R11 held tick third cycle", int'(alarm_irq), 0);
        sec_tick = 1'b0;
        @(negedge clk);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule